// File: doc/BRIEF.md
# Bus-Width Matching Read Port

This block sits between the read side of a 36-bit FIFO and a narrower consumer. Each FIFO entry is handed out as one full 36-bit long word, as two 18-bit halves or as four 9-bit quarters. Narrow pieces always appear in the low bits of the output register, and the bits above them are zero. Two strap inputs choose the width and a third chooses which end of the entry comes out first. The straps are captured only while master reset is held, so changing them later has no effect.

The block takes a new entry from the FIFO through a valid/pop handshake only when it holds no entry, or in the same cycle as it hands out the last piece of the entry it holds. A consumer read happens on a clock edge where the read enable is high and the active-low select is low. Each read loads the next piece into the output register and raises the output-valid flag for one cycle. Partial reset empties the output register and discards the entry that is partly consumed, but keeps the captured width and byte order.

Top module: `bus_match_rdport`

## Requirements
- R1: With `strap_bm` low at master reset, each read delivers one whole 36-bit entry on `dout`.
- R2: With `strap_bm` high and `strap_size` low at master reset, each entry is delivered as two 18-bit reads on `dout[17:0]`.
- R3: With `strap_bm` high and `strap_size` high at master reset, each entry is delivered as four 9-bit reads on `dout[8:0]`.
- R4: With `strap_big` high at master reset, the first read of an entry returns its most significant piece and later reads step toward the least significant.
- R5: With `strap_big` low at master reset, the first read of an entry returns its least significant piece and later reads step toward the most significant.
- R6: The straps are sampled only while `rst` is high. A strap change after reset leaves width and order unchanged.
- R7: The cycle after `rst` is high, `dout` is all zeros and `dout_valid` is low.
- R8: `prst` clears `dout` to zero, clears `dout_valid` and discards the held entry. The captured width and order are kept.
- R9: A clock edge without `rd_en` high and `rd_cs_n` low is not a read: `dout` holds and `dout_valid` is low in the following cycle.
- R10: `fifo_pop` is raised only when no entry is held, or when the last piece of the held entry is read in that cycle. The held entry does not change while pieces of it remain.
- R11: In the 18-bit mode `dout[35:18]` is zero, and in the 9-bit mode `dout[35:9]` is zero.
- R12: A read while no entry is held leaves `dout` unchanged and `dout_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst | input | 1 | Master reset, synchronous, active high; straps are sampled while it is high |
| prst | input | 1 | Partial reset, synchronous, active high |
| strap_bm | input | 1 | Width strap: low selects 36 bits, high selects a narrow width |
| strap_size | input | 1 | Narrow-width strap: high selects 9 bits, low selects 18 bits |
| strap_big | input | 1 | Order strap: high sends the most significant piece first |
| fifo_data | input | 36 | Head entry of the FIFO |
| fifo_valid | input | 1 | FIFO holds at least one entry |
| fifo_pop | output | 1 | Takes the head entry on this clock edge |
| rd_en | input | 1 | Read enable, active high |
| rd_cs_n | input | 1 | Read select, active low |
| dout | output | 36 | Output register, narrow pieces in the low bits |
| dout_valid | output | 1 | High for one cycle after each read that delivered a piece |

## Verification
The bench runs every combination of width and byte order. In each one it flips the straps right after reset, so a design that kept sampling them would scramble the piece order or the lane width. It stalls a read, both with the enable low and with the select high, in the middle of an entry, and it checks the FIFO depth there. A design that popped early would lose entries, and one that ignored the stall would skip pieces. It also reads an empty port, which a faulty design would answer with a stale valid pulse. Last, it applies a partial reset halfway through an entry while the straps are changed. A design that cleared its configuration or kept the old entry would return the wrong bytes afterwards.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  typedef enum logic [1:0] {
    BW_LONG    = 2'd0,
    BW_HALF    = 2'd1,
    BW_QUARTER = 2'd2
  } bw_e;

  typedef struct packed {
    bw_e  width;
    logic big;
  } cfg_t;

  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_LANES);

endpackage

// File: rtl/bmr_cfg_latch.sv
module bmr_cfg_latch
  import bmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strap_bm,
  input  logic strap_size,
  input  logic strap_big,
  output cfg_t cfg
);

  bw_e width_dec;

  always_comb begin
    if (!strap_bm)       width_dec = BW_LONG;
    else if (strap_size) width_dec = BW_QUARTER;
    else                 width_dec = BW_HALF;
  end

  // Straps are followed while reset is high; the last value before release sticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.width <= width_dec;
      cfg.big   <= strap_big;
    end
  end

  // R6: configuration frozen outside master reset
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg));

endmodule

// File: rtl/bmr_entry_hold.sv
module bmr_entry_hold
  import bmr_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic             clk,
  input  logic             clr,
  input  bw_e              width,
  input  logic [W-1:0]     fifo_data,
  input  logic             fifo_valid,
  output logic             fifo_pop,
  input  logic             rd_go,
  output logic             held,
  output logic [W-1:0]     cur,
  output logic [IDX_W-1:0] idx,
  output logic             fire
);

  logic last;
  logic consume;

  always_comb begin
    case (width)
      BW_LONG:    last = 1'b1;
      BW_HALF:    last = idx[0];
      BW_QUARTER: last = &idx;
      default:    last = 1'b1;
    endcase
  end

  assign fire     = rd_go & held;
  assign consume  = fire & last;
  assign fifo_pop = fifo_valid & ~clr & (~held | consume);

  always_ff @(posedge clk) begin
    if (clr) begin
      held <= 1'b0;
      idx  <= '0;
      cur  <= '0;
    end else if (fifo_pop) begin
      held <= 1'b1;
      idx  <= '0;
      cur  <= fifo_data;
    end else if (consume) begin
      held <= 1'b0;
      idx  <= '0;
    end else if (fire) begin
      idx  <= idx + 1'b1;
    end
  end

  // R10: entry stays put until its last piece is read
  p_entry_kept_r10: assert property (@(posedge clk) disable iff (clr)
    (held && !consume) |=> (held && $stable(cur)));

  // R2: half mode never walks past the second piece
  p_half_idx_r2: assert property (@(posedge clk) disable iff (clr)
    (width == BW_HALF) |-> (idx <= 1));

  // R1: long mode never advances the piece index
  p_long_idx_r1: assert property (@(posedge clk) disable iff (clr)
    (width == BW_LONG) |-> (idx == '0));

endmodule

// File: rtl/bmr_lane_sel.sv
module bmr_lane_sel
  import bmr_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  cfg_t             cfg,
  input  logic [W-1:0]     cur,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     piece
);

  localparam int unsigned H = W / 2;
  localparam int unsigned Q = W / 4;

  logic [H-1:0] half_l [2];
  logic [Q-1:0] qtr_l  [MAX_LANES];

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign half_l[g] = cur[g*H +: H];
  end

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_qtr
    assign qtr_l[g] = cur[g*Q +: Q];
  end

  logic             hsel;
  logic [IDX_W-1:0] qsel;

  // Big-endian order walks the lanes from the top down.
  assign hsel = cfg.big ? ~idx[0] : idx[0];
  assign qsel = cfg.big ? ~idx    : idx;

  always_comb begin
    piece = '0;
    case (cfg.width)
      BW_LONG:    piece          = cur;
      BW_HALF:    piece[H-1:0]   = half_l[hsel];
      BW_QUARTER: piece[Q-1:0]   = qtr_l[qsel];
      default:    piece          = cur;
    endcase
  end

endmodule

// File: rtl/bus_match_rdport.sv
module bus_match_rdport
  import bmr_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         prst,
  input  logic         strap_bm,
  input  logic         strap_size,
  input  logic         strap_big,
  input  logic [W-1:0] fifo_data,
  input  logic         fifo_valid,
  output logic         fifo_pop,
  input  logic         rd_en,
  input  logic         rd_cs_n,
  output logic [W-1:0] dout,
  output logic         dout_valid
);

  localparam int unsigned H = W / 2;
  localparam int unsigned Q = W / 4;

  cfg_t             cfg;
  logic             clr;
  logic             rd_go;
  logic             held;
  logic             fire;
  logic [W-1:0]     cur;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     piece;

  assign clr   = rst | prst;
  assign rd_go = rd_en & ~rd_cs_n;

  bmr_cfg_latch u_cfg (
    .clk        (clk),
    .rst        (rst),
    .strap_bm   (strap_bm),
    .strap_size (strap_size),
    .strap_big  (strap_big),
    .cfg        (cfg)
  );

  bmr_entry_hold #(.W(W)) u_hold (
    .clk        (clk),
    .clr        (clr),
    .width      (cfg.width),
    .fifo_data  (fifo_data),
    .fifo_valid (fifo_valid),
    .fifo_pop   (fifo_pop),
    .rd_go      (rd_go),
    .held       (held),
    .cur        (cur),
    .idx        (idx),
    .fire       (fire)
  );

  bmr_lane_sel #(.W(W)) u_sel (
    .cfg   (cfg),
    .cur   (cur),
    .idx   (idx),
    .piece (piece)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else if (fire) begin
      dout       <= piece;
      dout_valid <= 1'b1;
    end else begin
      dout_valid <= 1'b0;
    end
  end

  // R7: output register empty right after master reset
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dout == '0 && !dout_valid));

  // R8: partial reset empties the output register
  p_prst_clear_r8: assert property (@(posedge clk) disable iff (rst)
    prst |=> (dout == '0 && !dout_valid));

  // R9: no qualified read, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (clr)
    !rd_go |=> ($stable(dout) && !dout_valid));

  // R12: read with nothing held yields nothing
  p_empty_read_r12: assert property (@(posedge clk) disable iff (clr)
    (rd_go && !held) |=> ($stable(dout) && !dout_valid));

  // R11: unused upper lanes stay zero
  p_upper_zero_half_r11: assert property (@(posedge clk) disable iff (clr)
    (cfg.width == BW_HALF) |-> (dout[W-1:H] == '0));

  p_upper_zero_qtr_r11: assert property (@(posedge clk) disable iff (clr)
    (cfg.width == BW_QUARTER) |-> (dout[W-1:Q] == '0));

endmodule

// File: tb/sim_bus_match_rdport.sv
module sim_bus_match_rdport;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, prst;
  logic        strap_bm, strap_size, strap_big;
  logic [35:0] fifo_data;
  logic        fifo_valid;
  logic        fifo_pop;
  logic        rd_en, rd_cs_n;
  logic [35:0] dout;
  logic        dout_valid;

  logic [35:0] q[$];
  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_match_rdport #(.W(36)) u0 (
    .clk(clk), .rst(rst), .prst(prst),
    .strap_bm(strap_bm), .strap_size(strap_size), .strap_big(strap_big),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_pop(fifo_pop),
    .rd_en(rd_en), .rd_cs_n(rd_cs_n),
    .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_valid = (q.size() != 0);
    fifo_data  = (q.size() != 0) ? q[0] : 36'd0;
  endtask

  // Inputs are set at a falling edge; one full cycle then runs.
  task automatic tick();
    logic p;
    #1;
    p = fifo_pop;
    if (p && !fifo_valid) chk(1'b0, "R10 pop while empty", 36'd1, 36'd0);
    @(posedge clk);
    @(negedge clk);
    if (p) void'(q.pop_front());
    refresh();
  endtask

  task automatic apply_reset(input bit bm, input bit sz, input bit big);
    rst = 1'b1; strap_bm = bm; strap_size = sz; strap_big = big;
    rd_en = 1'b0; rd_cs_n = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
  endtask

  function automatic int lanes_of(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  // Expected piece i of entry e, computed from the requirements.
  function automatic logic [35:0] exp_piece(input logic [35:0] e, input int w, input bit big, input int i);
    int n, pw, p;
    logic [35:0] one, m;
    n   = lanes_of(w);
    pw  = 36 / n;
    p   = big ? (n - 1 - i) : i;
    one = 36'd1;
    m   = (one << pw) - 36'd1;
    return (e >> (p * pw)) & m;
  endfunction

  function automatic logic [35:0] entry_of(input int c, input int k);
    logic [35:0] a;
    a = 36'(k + 1) * 36'h3_5A7B_9C1D + 36'(c) * 36'h0_2468_ACE1;
    return a;
  endfunction

  initial begin
    rst = 1'b1; prst = 1'b0;
    strap_bm = 1'b0; strap_size = 1'b0; strap_big = 1'b0;
    rd_en = 1'b0; rd_cs_n = 1'b1;
    refresh();
    @(negedge clk);
    apply_reset(1'b0, 1'b0, 1'b0);
    tick();
    chk(dout == 36'd0, "R7 dout after reset", dout, 36'd0);
    chk(dout_valid == 1'b0, "R7 valid after reset", {35'd0, dout_valid}, 36'd0);

    for (int c = 0; c < 6; c++) begin
      int w, n;
      bit big, bm, sz;
      string tag;
      logic [35:0] held_val;
      w   = c / 2;
      big = c[0];
      bm  = (w != 0);
      sz  = (w == 2);
      n   = lanes_of(w);
      tag = $sformatf("%s %s R6", (w == 0) ? "R1" : (w == 1) ? "R2 R11" : "R3 R11",
                      big ? "R4" : "R5");
      apply_reset(bm, sz, big);
      strap_bm = ~bm; strap_size = ~sz; strap_big = ~big;
      for (int k = 0; k < 3; k++) q.push_back(entry_of(c, k));
      refresh();
      tick();
      chk(q.size() == 2, "R10 one entry taken when idle", 36'(q.size()), 36'd2);
      for (int k = 0; k < 3; k++) begin
        for (int i = 0; i < n; i++) begin
          logic [35:0] ex;
          ex = exp_piece(entry_of(c, k), w, big, i);
          rd_en = 1'b1; rd_cs_n = 1'b0;
          tick();
          chk(dout_valid && dout == ex, tag, dout, ex);
          if (k == 0 && i == 0) begin
            held_val = dout;
            rd_en = 1'b0; rd_cs_n = 1'b0;
            tick();
            chk(!dout_valid && dout == held_val, "R9 enable low", dout, held_val);
            rd_en = 1'b1; rd_cs_n = 1'b1;
            tick();
            chk(!dout_valid && dout == held_val, "R9 select high", dout, held_val);
            chk(q.size() == ((n == 1) ? 1 : 2), "R10 no early pop",
                36'(q.size()), 36'((n == 1) ? 1 : 2));
          end
        end
      end
      held_val = dout;
      rd_en = 1'b1; rd_cs_n = 1'b0;
      tick();
      chk(!dout_valid && dout == held_val, "R12 read when empty", dout, held_val);
      rd_en = 1'b0; rd_cs_n = 1'b1;
    end

    // Partial reset in the middle of an entry, byte width, big-endian.
    begin
      logic [35:0] e0, e1, ex;
      e0 = 36'hA_BCDE_F012;
      e1 = 36'h5_6789_1A2B;
      apply_reset(1'b1, 1'b1, 1'b1);
      q.push_back(e0); q.push_back(e1);
      refresh();
      tick();
      rd_en = 1'b1; rd_cs_n = 1'b0;
      tick();
      ex = exp_piece(e0, 2, 1'b1, 0);
      chk(dout_valid && dout == ex, "R3 R4 before partial reset", dout, ex);
      rd_en = 1'b0; rd_cs_n = 1'b1;
      prst = 1'b1; strap_bm = 1'b0; strap_size = 1'b0; strap_big = 1'b0;
      tick();
      prst = 1'b0;
      chk(dout == 36'd0 && !dout_valid, "R8 output cleared", dout, 36'd0);
      chk(q.size() == 1, "R8 no pop during partial reset", 36'(q.size()), 36'd1);
      tick();
      for (int i = 0; i < 4; i++) begin
        ex = exp_piece(e1, 2, 1'b1, i);
        rd_en = 1'b1; rd_cs_n = 1'b0;
        tick();
        chk(dout_valid && dout == ex, "R8 config kept, held entry dropped", dout, ex);
      end
      rd_en = 1'b0; rd_cs_n = 1'b1;
      chk(dout != 36'd0, "R7 precondition nonzero output", dout, 36'd1);
      apply_reset(1'b0, 1'b0, 1'b0);
      tick();
      chk(dout == 36'd0 && !dout_valid, "R7 dout cleared by master reset", dout, 36'd0);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule